// File: doc/BRIEF.md
# Timer Compare/Capture Flag Unit

This block is a free-running 16-bit timer. It has three output-compare channels and a fourth channel that works as either an input capture or a fourth output compare. Each timer event raises a bit in an 8-bit event-flag register. Software clears a flag by writing a one to its position. A mask register has the same bit layout as the flag register. Any flag whose mask bit is one drives a single registered interrupt request.

Software reaches the unit through a simple synchronous register port. A write takes effect at the clock edge that samples it. The read data is registered: it appears one clock after the address is presented, and it reflects the state before that edge. The capture input is asynchronous. It passes through a two-flop synchronizer, and an edge detector then picks rising edges, falling edges, both, or none.

Top module: `tmr_flag_unit`

Register map (`reg_addr`): 0 counter (read-only, writes ignored), 1 compare A, 2 compare B, 3 compare C, 4 channel-4 value (compare value, or latched capture value), 5 control, 6 flags, 7 mask. The flag and mask registers use bits [7:0] of the data word. All other bits read as zero.

## Requirements
- R1: After reset, the flag register, the mask register, the control register, the counter and `irq` are all zero.
- R2: The flag layout is: bit 7 compare A, bit 6 compare B, bit 5 compare C, bit 4 channel 4, bit 3 overflow. Bits 2..0 of the flag and mask registers always read zero, even after a write of ones.
- R3: The counter increments by one every clock. A read of address 0 returns the counter value in the cycle the address was presented.
- R4: For compare channels A, B and C, the flag is set at the clock edge that ends a cycle in which the counter equals that channel's compare register, and not earlier.
- R5: Flag bit 3 is set at the edge where the counter wraps from 0xFFFF to 0x0000.
- R6: Control bit 0 selects the channel-4 mode: 0 = compare, 1 = capture. In compare mode, flag bit 4 follows the same timing as R4, using register 4.
- R7: Control bits [2:1] select the capture edge: 01 rising, 10 falling, 11 both, 00 none. An edge that is not selected has no effect. On a selected edge, the flag is set at the third clock edge after the pin changes. Register 4 then holds the counter value of the cycle before that edge.
- R8: Writing a one to a flag bit clears it. Writing a zero leaves it unchanged.
- R9: If a set event and a write-one-to-clear hit the same flag in the same cycle, the flag stays set.
- R10: `irq` is the OR over bits 7..3 of (flag AND mask), registered for one clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cap_in | input | 1 | Asynchronous capture input for channel 4 |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Registered read data |
| irq | output | 1 | Combined interrupt request |

## Verification
Two situations are hard to reach from the ports.

The first is a compare match that lands in the same cycle as a clearing write to the same flag. To reach it, the bench tracks the counter itself. It loads a compare value a fixed distance ahead of the counter, then issues the clearing write at exactly the matching edge.

The second is the overflow wrap. It only occurs after 65536 clocks. The bench runs the counter up to 0xFFFE and then samples the flag and `irq` edge by edge across the wrap.

// File: rtl/tfu_pkg.sv
package tfu_pkg;
  localparam int FLAG_W    = 8;
  localparam int FB_CMPA   = 7;
  localparam int FB_CMPB   = 6;
  localparam int FB_CMPC   = 5;
  localparam int FB_CH4    = 4;
  localparam int FB_OVF    = 3;
  localparam logic [FLAG_W-1:0] FLAG_IMPL = 8'hF8;

  localparam logic [2:0] RA_CNT  = 3'd0;
  localparam logic [2:0] RA_CMPA = 3'd1;
  localparam logic [2:0] RA_CH4  = 3'd4;
  localparam logic [2:0] RA_CTRL = 3'd5;
  localparam logic [2:0] RA_FLAG = 3'd6;
  localparam logic [2:0] RA_MASK = 3'd7;

  typedef enum logic [1:0] {
    EDGE_NONE = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_FALL = 2'b10,
    EDGE_BOTH = 2'b11
  } edge_sel_e;
endpackage

// File: rtl/tfu_counter.sv
module tfu_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  output logic [CNT_W-1:0] cnt,
  output logic             at_top
);
  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else     cnt <= cnt + 1'b1;
  end

  // the next edge wraps the count to zero
  assign at_top = &cnt;
endmodule

// File: rtl/tfu_cap_edge.sv
module tfu_cap_edge
  import tfu_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      pin,
  input  edge_sel_e sel,
  output logic      hit
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;

  genvar s;
  generate
    for (s = 0; s < SYNC_STAGES; s++) begin : g_sync
      always_ff @(posedge clk) begin
        if (rst) sync_q[s] <= 1'b0;
        else if (s == 0) sync_q[s] <= pin;
        else sync_q[s] <= sync_q[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= sync_q[SYNC_STAGES-1];
  end

  logic now_v, rise, fall;
  assign now_v = sync_q[SYNC_STAGES-1];
  assign rise  = now_v & ~prev_q;
  assign fall  = ~now_v & prev_q;

  always_comb begin
    unique case (sel)
      EDGE_RISE: hit = rise;
      EDGE_FALL: hit = fall;
      EDGE_BOTH: hit = rise | fall;
      default:   hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/tfu_flags.sv
module tfu_flags
  import tfu_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [FLAG_W-1:0] set_vec,
  input  logic [FLAG_W-1:0] clr_vec,
  output logic [FLAG_W-1:0] flags
);
  // a set event outranks a clear in the same cycle
  always_ff @(posedge clk) begin
    if (rst) flags <= '0;
    else     flags <= ((flags & ~clr_vec) | set_vec) & FLAG_IMPL;
  end
endmodule

// File: rtl/tmr_flag_unit.sv
module tmr_flag_unit
  import tfu_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int NUM_CMP     = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cap_in,
  input  logic             reg_we,
  input  logic [2:0]       reg_addr,
  input  logic [CNT_W-1:0] reg_wdata,
  output logic [CNT_W-1:0] reg_rdata,
  output logic             irq
);
  localparam int PAD_W = CNT_W - FLAG_W;

  logic [CNT_W-1:0]              cnt;
  logic                          at_top;
  logic [NUM_CMP-1:0][CNT_W-1:0] cmp_q;
  logic [NUM_CMP-1:0]            cmp_hit;
  logic [CNT_W-1:0]              ch4_q;
  logic                          mode_cap_q;
  edge_sel_e                     esel_q;
  logic [FLAG_W-1:0]             mask_q;
  logic [FLAG_W-1:0]             flags;
  logic [FLAG_W-1:0]             set_vec, clr_vec;
  logic                          cap_hit, ch4_evt;
  logic                          irq_q;
  logic [CNT_W-1:0]              rdata_q;

  tfu_counter #(.CNT_W(CNT_W)) cnt_i (
    .clk(clk), .rst(rst), .cnt(cnt), .at_top(at_top)
  );

  tfu_cap_edge #(.SYNC_STAGES(SYNC_STAGES)) cap_i (
    .clk(clk), .rst(rst), .pin(cap_in), .sel(esel_q), .hit(cap_hit)
  );

  genvar i;
  generate
    for (i = 0; i < NUM_CMP; i++) begin : g_cmp
      always_ff @(posedge clk) begin
        if (rst) cmp_q[i] <= '0;
        else if (reg_we && reg_addr == RA_CMPA + 3'(i)) cmp_q[i] <= reg_wdata;
      end
      assign cmp_hit[i] = (cnt == cmp_q[i]);
    end
  endgenerate

  // channel 4: capture takes priority over a software write
  always_ff @(posedge clk) begin
    if (rst) ch4_q <= '0;
    else if (mode_cap_q && cap_hit) ch4_q <= cnt;
    else if (reg_we && reg_addr == RA_CH4) ch4_q <= reg_wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_cap_q <= 1'b0;
      esel_q     <= EDGE_NONE;
      mask_q     <= '0;
    end else if (reg_we) begin
      if (reg_addr == RA_CTRL) begin
        mode_cap_q <= reg_wdata[0];
        esel_q     <= edge_sel_e'(reg_wdata[2:1]);
      end
      if (reg_addr == RA_MASK) mask_q <= reg_wdata[FLAG_W-1:0] & FLAG_IMPL;
    end
  end

  assign ch4_evt = mode_cap_q ? cap_hit : (cnt == ch4_q);

  always_comb begin
    set_vec          = '0;
    set_vec[FB_CMPA] = cmp_hit[0];
    set_vec[FB_CMPB] = cmp_hit[1];
    set_vec[FB_CMPC] = cmp_hit[2];
    set_vec[FB_CH4]  = ch4_evt;
    set_vec[FB_OVF]  = at_top;
  end

  assign clr_vec = (reg_we && reg_addr == RA_FLAG) ? reg_wdata[FLAG_W-1:0] : '0;

  tfu_flags flg_i (
    .clk(clk), .rst(rst), .set_vec(set_vec), .clr_vec(clr_vec), .flags(flags)
  );

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= |(flags & mask_q);
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_q <= '0;
    else begin
      unique case (reg_addr)
        3'd0:    rdata_q <= cnt;
        3'd1:    rdata_q <= cmp_q[0];
        3'd2:    rdata_q <= cmp_q[1];
        3'd3:    rdata_q <= cmp_q[2];
        3'd4:    rdata_q <= ch4_q;
        3'd5:    rdata_q <= {{(CNT_W-3){1'b0}}, esel_q, mode_cap_q};
        3'd6:    rdata_q <= {{PAD_W{1'b0}}, flags};
        default: rdata_q <= {{PAD_W{1'b0}}, mask_q};
      endcase
    end
  end

  assign reg_rdata = rdata_q;
  assign irq       = irq_q;
endmodule

// File: rtl/tfu_checker.sv
module tfu_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] cmp_a,
  input logic [7:0]       flags,
  input logic [7:0]       mask,
  input logic             irq,
  input logic             we,
  input logic [2:0]       addr,
  input logic [CNT_W-1:0] wdata
);
  a_r2_low_bits_zero: assert property (@(posedge clk) disable iff (rst)
    flags[2:0] == 3'b000 && mask[2:0] == 3'b000);

  a_r4_cmpa_sets: assert property (@(posedge clk) disable iff (rst)
    (cnt == cmp_a) |=> flags[7]);

  a_r5_wrap_sets: assert property (@(posedge clk) disable iff (rst)
    (&cnt) |=> (flags[3] && cnt == '0));

  a_r8_w1c_clears: assert property (@(posedge clk) disable iff (rst)
    (we && addr == 3'd6 && wdata[7] && cnt != cmp_a) |=> !flags[7]);

  a_r10_irq_high: assert property (@(posedge clk) disable iff (rst)
    (|(flags & mask)) |=> irq);

  a_r10_irq_low: assert property (@(posedge clk) disable iff (rst)
    !(|(flags & mask)) |=> !irq);
endmodule

bind tmr_flag_unit tfu_checker #(.CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst(rst), .cnt(cnt), .cmp_a(cmp_q[0]), .flags(flags),
  .mask(mask_q), .irq(irq), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata)
);

// File: tb/tmr_flag_unit_tb_top.sv
`timescale 1ns/1ps
module tmr_flag_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cap_in = 1'b0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_addr = 3'd0;
  logic [15:0] reg_wdata = 16'd0;
  logic [15:0] reg_rdata;
  logic        irq;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  logic [15:0] bc;   // bench model of the free-running count

  always #10 clk = ~clk;

  tmr_flag_unit dut_i (
    .clk(clk), .rst(rst), .cap_in(cap_in), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  always @(posedge clk) begin
    if (rst) bc <= 16'd0;
    else     bc <= bc + 16'd1;
  end

  // {channel[3:0], delta[7:0], extra wait[7:0], expect[3:0]}
  localparam logic [23:0] VECS [0:7] = '{
    {4'd0, 8'd4, 8'd4, 4'd1}, {4'd0, 8'd4, 8'd3, 4'd0},
    {4'd1, 8'd6, 8'd6, 4'd1}, {4'd1, 8'd6, 8'd5, 4'd0},
    {4'd2, 8'd3, 8'd3, 4'd1}, {4'd2, 8'd9, 8'd8, 4'd0},
    {4'd3, 8'd5, 8'd5, 4'd1}, {4'd3, 8'd2, 8'd1, 4'd0}
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic idle(input int n);
    for (int j = 0; j < n; j++) @(negedge clk);
  endtask

  initial begin
    #(150000 * 20);
    if (!done) begin
      failures++;
      $display("FAIL watchdog act=%h exp=%h", 16'd0, 16'd1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [15:0] v, c, e;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    check("R1 irq", {15'd0, irq}, 16'd0);
    rd(3'd6, v); check("R1 flags", v, 16'h0000);
    rd(3'd7, v); check("R1 mask", v, 16'h0000);
    rd(3'd5, v); check("R1 ctrl", v, 16'h0000);

    // R3 counter read
    c = bc; rd(3'd0, v); check("R3 counter", v, c);
    wr(3'd0, 16'h1234);
    c = bc; rd(3'd0, v); check("R3 counter not writable", v, c);

    // R2 unimplemented bits
    wr(3'd7, 16'h00FF); rd(3'd7, v); check("R2 mask low bits", v, 16'h00F8);
    wr(3'd7, 16'h0000);
    wr(3'd6, 16'h00FF); rd(3'd6, v); check("R2 flag low bits", v & 16'h0007, 16'h0000);

    // R4 / R6 compare table
    for (int n = 0; n < 8; n++) begin
      logic [3:0] ch; logic [7:0] dl, kw; logic [3:0] ex;
      {ch, dl, kw, ex} = VECS[n];
      wr(3'd6, 16'h00F8);
      c = bc;
      wr(3'd1 + ch[2:0], c + {8'd0, dl});
      idle(kw);
      rd(3'd6, v);
      e = {15'd0, ex[0]};
      check((ch == 4'd3) ? "R6 ch4 compare" : "R4 compare", (v >> (7 - ch)) & 16'd1, e);
    end

    // R9 set beats clear, R8 zero write ignored, one clears
    wr(3'd6, 16'h00F8);
    c = bc;
    wr(3'd1, c + 16'd5);
    idle(4);
    wr(3'd6, 16'h0080);
    rd(3'd6, v); check("R9 set wins", v & 16'h0080, 16'h0080);
    wr(3'd6, 16'h0000);
    rd(3'd6, v); check("R8 zero write keeps", v & 16'h0080, 16'h0080);
    wr(3'd6, 16'h0080);
    rd(3'd6, v); check("R8 one clears", v & 16'h0080, 16'h0000);

    // R10 irq gating and one-cycle lag
    wr(3'd7, 16'h0000);
    wr(3'd6, 16'h00F8);
    c = bc;
    wr(3'd1, c + 16'd3);
    idle(6);
    check("R10 masked off", {15'd0, irq}, 16'd0);
    wr(3'd7, 16'h0080);
    check("R10 registered lag", {15'd0, irq}, 16'd0);
    @(negedge clk);
    check("R10 irq on", {15'd0, irq}, 16'd1);
    wr(3'd7, 16'h0000);

    // R7 capture, rising edge only
    wr(3'd5, 16'h0003);
    wr(3'd6, 16'h00F8);
    cap_in = 1'b1;
    @(negedge clk);
    rd(3'd6, v); check("R7 not yet (2)", v & 16'h0010, 16'h0000);
    e = bc;
    rd(3'd6, v); check("R7 not yet (3)", v & 16'h0010, 16'h0000);
    rd(3'd6, v); check("R7 rise flag", v & 16'h0010, 16'h0010);
    rd(3'd4, v); check("R7 captured count", v, e);
    wr(3'd6, 16'h0010);
    cap_in = 1'b0; idle(6);
    rd(3'd6, v); check("R7 fall ignored", v & 16'h0010, 16'h0000);
    rd(3'd4, v); check("R7 value held", v, e);

    // R7 falling edge select
    wr(3'd5, 16'h0005);
    cap_in = 1'b1; idle(6);
    rd(3'd6, v); check("R7 rise ignored", v & 16'h0010, 16'h0000);
    cap_in = 1'b0; idle(6);
    rd(3'd6, v); check("R7 fall flag", v & 16'h0010, 16'h0010);

    // R7 none selected
    wr(3'd5, 16'h0001);
    wr(3'd6, 16'h0010);
    cap_in = 1'b1; idle(6);
    rd(3'd6, v); check("R7 none", v & 16'h0010, 16'h0000);
    cap_in = 1'b0;

    // R5 overflow across the wrap
    wr(3'd5, 16'h0000);
    wr(3'd7, 16'h0008);
    wr(3'd6, 16'h00F8);
    while (bc != 16'hFFFE) @(negedge clk);
    rd(3'd6, v);
    rd(3'd6, v); check("R5 before wrap", v & 16'h0008, 16'h0000);
    check("R10 no irq before wrap", {15'd0, irq}, 16'd0);
    rd(3'd6, v); check("R5 wrap flag", v & 16'h0008, 16'h0008);
    check("R10 irq after wrap", {15'd0, irq}, 16'd1);
    c = bc; rd(3'd0, v); check("R3 wrapped count", v, c);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule